// File: doc/BRIEF.md
# IO Port Target Decoder

This block sits on the target side of a PCI-style bus and decides, for every IO transaction, whether the local port answers and how the transaction ends. During the address phase it captures the 32-bit IO address and the bus command. In the first data phase it looks at the byte enables and at the framing signals. From these it decides three things: whether the transaction is claimed, whether it has to be ended with a target abort because the byte-enable pattern is illegal, and whether the initiator asked for more than one data phase, which forces a disconnect.

The port is configured at run time with a base address and a width of 8, 16 or 32 bits. A 32-bit port owns a whole IO dword and decodes on the dword address alone. A narrow port decodes the full byte address. In that case the two low address bits give the first byte lane the initiator wants. An enable on a lane below that one is illegal, and so is an enable on a lane the port does not own. The data path and the port's register contents are handled elsewhere.

Top module: `io_tgt_decode`

## Requirements
- R1: While reset is high and after it is released, `claim_o` and `tabort_o` are 0 and `disc_o` is 0 (no disconnect).
- R2: Only command code 4'b0010 (IO read) and command code 4'b0011 (IO write) can be claimed. Every other command value gives no claim.
- R3: With width code 2 (32-bit port), the claim depends only on address bits 31:2 equal to base bits 31:2. Address bits 1:0 are ignored, any byte-enable pattern is accepted, and the transaction is never aborted.
- R4: With width code 0 (8-bit) or 1 (16-bit), the port occupies the bytes from the base, aligned down to the port size, upward through size-1. All 32 address bits must select one of those bytes for a claim.
- R5: For an 8-bit or 16-bit port, the active-low byte enable of the lane named by address bits 1:0 (bit n of `bus_be_n_i` is lane n) must be 0. Otherwise no claim is made.
- R6: A claimed transaction on an 8-bit or 16-bit port that has any byte enable asserted on a lane lower than address bits 1:0 gets `tabort_o`=1. `tabort_o` is only ever 1 together with `claim_o`.
- R7: A claimed transaction on an 8-bit or 16-bit port that has any byte enable asserted on a lane the port does not occupy gets `tabort_o`=1.
- R8: If frame is still asserted in the data-phase cycle where ready is first sampled high, the request is multi-phase. A claimed, non-aborted multi-phase request reports `disc_o`=1 (disconnect with data in the first phase) when `cfg_disc_mode_i`=0, and `disc_o`=2 (disconnect without data in the second phase) when it is 1. In all other cases `disc_o`=0.
- R9: The decision is taken at the first clock edge after the address phase at which `bus_irdy_i` is high. Cycles with ready low delay it. The outputs change right after that edge and hold until the next address phase, whose clock edge clears all three outputs.
- R10: Width code 3 is reserved and never claims.
- R11: An address phase is recognised only at a clock edge where frame is high and was low at the previous edge. A frame held high after a decision starts no new decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_frame_i | input | 1 | Frame asserted (active high) |
| bus_irdy_i | input | 1 | Initiator ready asserted (active high) |
| bus_addr_i | input | ADDR_W | IO byte address, sampled in the address phase |
| bus_cmd_i | input | 4 | Bus command, sampled in the address phase |
| bus_be_n_i | input | 4 | Active-low byte enables of the first data phase |
| cfg_base_i | input | ADDR_W | Port base address |
| cfg_width_i | input | 2 | Port width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| cfg_disc_mode_i | input | 1 | Multi-phase response: 0 = disconnect with data, 1 = disconnect without data |
| claim_o | output | 1 | Transaction claimed |
| tabort_o | output | 1 | Terminate with target abort |
| disc_o | output | 2 | 0 = none, 1 = disconnect with data, 2 = disconnect without data |

## Verification
If the captured address or command were wrong, the error would show up as a wrong claim in the cycle after the first ready edge. The sweep covers every byte-enable pattern against every start lane, four port widths and two base alignments, so any mask or lane error in the legality logic gives a wrong `tabort_o` or `claim_o` at that edge. A phase controller stuck in the wrong state shows in one of two ways. Either the outputs are not cleared at the edge after the address phase, or they change during ready wait cycles or while frame is held high. Both are checked at the cycle where they would first appear.

// File: rtl/io_tgt_pkg.sv
package io_tgt_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);

    localparam logic [3:0] CMD_IO_RD = 4'b0010;
    localparam logic [3:0] CMD_IO_WR = 4'b0011;

    typedef enum logic [1:0] {
        PW_8    = 2'd0,
        PW_16   = 2'd1,
        PW_32   = 2'd2,
        PW_RSVD = 2'd3
    } port_width_e;

    typedef enum logic [1:0] {
        DISC_NONE      = 2'd0,
        DISC_WITH_DATA = 2'd1,
        DISC_NO_DATA   = 2'd2
    } disc_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic  claim;
        logic  abort;
        disc_e disc;
    } verdict_t;

    function automatic logic [LANES-1:0] lane_onehot(input logic [LANE_W-1:0] lane);
        return LANES'(1) << lane;
    endfunction

    // Lanes occupied by the port, given the low base bits.
    function automatic logic [LANES-1:0] port_lanes(input port_width_e w,
                                                     input logic [LANE_W-1:0] base_lo);
        logic [LANES-1:0] m;
        case (w)
            PW_8:    m = lane_onehot(base_lo);
            PW_16:   m = 4'b0011 << {base_lo[1], 1'b0};
            PW_32:   m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

    function automatic logic is_io_cmd(input logic [3:0] cmd);
        return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
    endfunction

endpackage

// File: rtl/io_addr_match.sv
module io_addr_match
    import io_tgt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  port_width_e       width_i,
    output logic              hit_o,
    output logic [LANES-1:0]  port_mask_o
);
    localparam int DW_LSB = LANE_W;

    logic             dword_hit;
    logic [LANES-1:0] mask;
    logic             lane_hit;

    always_comb begin
        dword_hit = (addr_i[ADDR_W-1:DW_LSB] == base_i[ADDR_W-1:DW_LSB]);
        mask      = port_lanes(width_i, base_i[LANE_W-1:0]);
        // A 32-bit port ignores the low address bits.
        lane_hit  = (width_i == PW_32) ? 1'b1 : mask[addr_i[LANE_W-1:0]];
        hit_o       = dword_hit && lane_hit && (width_i != PW_RSVD);
        port_mask_o = mask;
    end

endmodule

// File: rtl/io_be_check.sv
module io_be_check
    import io_tgt_pkg::*;
(
    input  logic [LANES-1:0]  be_n_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [LANES-1:0]  port_mask_i,
    input  port_width_e       width_i,
    output logic              lane_on_o,
    output logic              illegal_o
);
    logic [LANES-1:0] be_act;
    logic [LANES-1:0] lane_bit;
    logic [LANES-1:0] bad_lane;
    logic             narrow;

    assign be_act   = ~be_n_i;
    assign lane_bit = lane_onehot(lane_i);
    assign narrow   = (width_i == PW_8) || (width_i == PW_16);

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            // Lane k is bad if enabled while below the start lane or outside the port.
            assign bad_lane[k] = be_act[k] &&
                                 ((k < int'(lane_i)) || !port_mask_i[k]);
        end
    endgenerate

    assign lane_on_o = narrow ? |(be_act & lane_bit) : 1'b1;
    assign illegal_o = narrow && (|bad_lane);

endmodule

// File: rtl/io_phase_ctl.sv
module io_phase_ctl
    import io_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_i,
    input  logic irdy_i,
    output logic start_o,
    output logic eval_o
);
    phase_e state_q;
    logic   frame_q;

    assign start_o = (state_q == PH_IDLE) && frame_i && !frame_q;
    assign eval_o  = (state_q == PH_DATA) && irdy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            frame_q <= 1'b0;
        end else begin
            frame_q <= frame_i;
            case (state_q)
                PH_IDLE: if (start_o) state_q <= PH_DATA;
                PH_DATA: if (eval_o)  state_q <= PH_IDLE;
                default:              state_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/io_tgt_decode.sv
module io_tgt_decode
    import io_tgt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_frame_i,
    input  logic              bus_irdy_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [3:0]        bus_cmd_i,
    input  logic [3:0]        bus_be_n_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [1:0]        cfg_width_i,
    input  logic              cfg_disc_mode_i,
    output logic              claim_o,
    output logic              tabort_o,
    output logic [1:0]        disc_o
);
    logic              start_w;
    logic              eval_w;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        cmd_q;
    port_width_e       width;
    logic              hit;
    logic [LANES-1:0]  port_mask;
    logic              lane_on;
    logic              illegal;
    verdict_t          next_v;
    verdict_t          verdict_q;

    assign width = port_width_e'(cfg_width_i);

    io_phase_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .frame_i (bus_frame_i),
        .irdy_i  (bus_irdy_i),
        .start_o (start_w),
        .eval_o  (eval_w)
    );

    io_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr_i      (addr_q),
        .base_i      (cfg_base_i),
        .width_i     (width),
        .hit_o       (hit),
        .port_mask_o (port_mask)
    );

    io_be_check u_be (
        .be_n_i      (bus_be_n_i),
        .lane_i      (addr_q[LANE_W-1:0]),
        .port_mask_i (port_mask),
        .width_i     (width),
        .lane_on_o   (lane_on),
        .illegal_o   (illegal)
    );

    always_comb begin
        next_v.claim = is_io_cmd(cmd_q) && hit && lane_on;
        next_v.abort = next_v.claim && illegal;
        if (next_v.claim && !next_v.abort && bus_frame_i)
            next_v.disc = cfg_disc_mode_i ? DISC_NO_DATA : DISC_WITH_DATA;
        else
            next_v.disc = DISC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            cmd_q     <= '0;
            verdict_q <= '{claim: 1'b0, abort: 1'b0, disc: DISC_NONE};
        end else if (start_w) begin
            addr_q    <= bus_addr_i;
            cmd_q     <= bus_cmd_i;
            verdict_q <= '{claim: 1'b0, abort: 1'b0, disc: DISC_NONE};
        end else if (eval_w) begin
            verdict_q <= next_v;
        end
    end

    assign claim_o  = verdict_q.claim;
    assign tabort_o = verdict_q.abort;
    assign disc_o   = verdict_q.disc;

endmodule

// File: rtl/io_tgt_decode_chk.sv
module io_tgt_decode_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_i,
    input logic [1:0] width_i,
    input logic       start_i,
    input logic       eval_i,
    input logic       claim_i,
    input logic       abort_i,
    input logic [1:0] disc_i
);
    AST_ABORT_WITH_CLAIM: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> claim_i); // R6

    AST_DISC_LEGAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (disc_i != 2'd0) |-> (claim_i && !abort_i)); // R8

    AST_DISC_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        disc_i != 2'd3); // R8

    AST_SINGLE_NO_DISC: assert property (@(posedge clk) disable iff (rst)
        (eval_i && !frame_i) |=> (disc_i == 2'd0)); // R8

    AST_RSVD_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (eval_i && width_i == 2'd3) |=> !claim_i); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!claim_i && !abort_i && disc_i == 2'd0)); // R9

    AST_HOLD_OUTSIDE_EVAL: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !eval_i) |=> ($stable(claim_i) && $stable(abort_i) && $stable(disc_i))); // R9

endmodule

bind io_tgt_decode io_tgt_decode_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .frame_i (bus_frame_i),
    .width_i (cfg_width_i),
    .start_i (start_w),
    .eval_i  (eval_w),
    .claim_i (claim_o),
    .abort_i (tabort_o),
    .disc_i  (disc_o)
);

// File: tb/sim_io_tgt_decode.sv
module sim_io_tgt_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame = 1'b0;
    logic        irdy = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  cmd = '0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] base = '0;
    logic [1:0]  width = '0;
    logic        mode = 1'b0;
    logic        claim, tabort;
    logic [1:0]  disc;
    int          tests = 0;
    int          fails = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    io_tgt_decode u0 (
        .clk(clk), .rst(rst), .bus_frame_i(frame), .bus_irdy_i(irdy),
        .bus_addr_i(addr), .bus_cmd_i(cmd), .bus_be_n_i(be_n),
        .cfg_base_i(base), .cfg_width_i(width), .cfg_disc_mode_i(mode),
        .claim_o(claim), .tabort_o(tabort), .disc_o(disc)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (addr=%h be_n=%h w=%0d base=%h)",
                     tag, act, exp, addr, be_n, width, base);
        end
    endtask

    function automatic logic [3:0] outs();
        return {claim, tabort, disc};
    endfunction

    // Expected {claim, abort, disc} and the requirement tag it exercises.
    function automatic logic [3:0] model(input logic [31:0] a, input logic [3:0] c,
                                         input logic [3:0] b, input logic [31:0] bs,
                                         input logic [1:0] w, input logic multi,
                                         input logic m, output string tag);
        logic ok_cmd, match, lane_on, low_bad, out_bad, cl, ab;
        logic [31:0] bal;
        int size, lane, plo;
        logic [1:0] d;
        ok_cmd = (c == 4'd2) || (c == 4'd3);
        low_bad = 0; out_bad = 0; lane_on = 1;
        lane = int'(a[1:0]);
        if (w == 2'd3) begin
            match = 0;
        end else if (w == 2'd2) begin
            match = (a[31:2] == bs[31:2]);
        end else begin
            size = (w == 2'd1) ? 2 : 1;
            bal  = (w == 2'd1) ? (bs & ~32'd1) : bs;
            match = (a >= bal) && (a < bal + size);
            lane_on = !b[lane];
            plo = int'(bal[1:0]);
            for (int k = 0; k < 4; k++) begin
                if (!b[k] && k < lane) low_bad = 1;
                if (!b[k] && (k < plo || k >= plo + size)) out_bad = 1;
            end
        end
        cl = ok_cmd && match && lane_on;
        ab = cl && (low_bad || out_bad);
        d  = (cl && !ab && multi) ? (m ? 2'd2 : 2'd1) : 2'd0;
        if (w == 2'd3)          tag = "R10";
        else if (!ok_cmd)       tag = "R2";
        else if (w == 2'd2)     tag = "R3";
        else if (!match)        tag = "R4";
        else if (!lane_on)      tag = "R5";
        else if (low_bad)       tag = "R6";
        else if (out_bad)       tag = "R7";
        else if (multi)         tag = "R8";
        else                    tag = "R4";
        return {cl, ab, d};
    endfunction

    // One transaction; called and returns at a falling edge.
    task automatic txn(input logic [31:0] a, input logic [3:0] c, input logic [3:0] b,
                       input logic multi, input int waits, input logic [3:0] exp,
                       input string tag);
        frame = 1; irdy = 0; addr = a; cmd = c;
        @(negedge clk);
        chk("R9", outs(), 4'h0);
        addr = ~a; cmd = ~c; be_n = b;
        for (int i = 0; i < waits; i++) begin
            irdy = 0;
            @(negedge clk);
            chk("R9", outs(), 4'h0);
        end
        irdy = 1; frame = multi;
        @(negedge clk);
        chk(tag, outs(), exp);
        frame = 0; irdy = 0;
        @(negedge clk);
        chk("R9", outs(), exp);
    endtask

    initial begin
        logic [31:0] bases [2];
        logic [31:0] a;
        logic [3:0]  e;
        string       tg;
        bases[0] = 32'h0000_1235;
        bases[1] = 32'h0000_1232;

        repeat (3) @(negedge clk);
        chk("R1", outs(), 4'h0);
        rst = 0;
        @(negedge clk);
        chk("R1", outs(), 4'h0);

        // Main sweep: widths, base alignments, start addresses, all enable patterns.
        for (int w = 0; w < 4; w++) begin
            for (int bi = 0; bi < 2; bi++) begin
                for (int ai = 0; ai < 9; ai++) begin
                    for (int be = 0; be < 16; be++) begin
                        for (int mu = 0; mu < 2; mu++) begin
                            base  = bases[bi];
                            width = 2'(w);
                            mode  = be[0] ^ mu[0];
                            if (ai < 4)      a = {bases[bi][31:2], 2'(ai)};
                            else if (ai < 8) a = {bases[bi][31:2], 2'(ai - 4)} ^ 32'h8000_0000;
                            else             a = {bases[bi][31:2], 2'b00} + 32'd4;
                            e = model(a, (ai[0] ? 4'd3 : 4'd2), 4'(be), base, width,
                                      mu[0], mode, tg);
                            txn(a, (ai[0] ? 4'd3 : 4'd2), 4'(be), mu[0], 0, e, tg);
                        end
                    end
                end
            end
        end

        // Every command code on a legal single-byte access.
        base = 32'h0000_0080; width = 2'd0; mode = 0;
        for (int c = 0; c < 16; c++) begin
            e = model(32'h80, 4'(c), 4'hE, base, width, 1'b0, mode, tg);
            txn(32'h80, 4'(c), 4'hE, 1'b0, 0, e, "R2");
        end

        // Ready wait states delay the decision (R9), multi-phase in both modes (R8).
        base = 32'h0000_0402; width = 2'd1;
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            e = model(32'h402, 4'd2, 4'h3, base, width, 1'b1, mode, tg);
            txn(32'h402, 4'd2, 4'h3, 1'b1, 3, e, "R9");
        end

        // R11: frame held high after a decision starts nothing new.
        base = 32'h0000_0300; width = 2'd2; mode = 0;
        frame = 1; irdy = 0; addr = 32'h0000_9000; cmd = 4'd2;
        @(negedge clk);
        be_n = 4'h0; irdy = 1;
        @(negedge clk);
        chk("R11", outs(), 4'h0);
        addr = 32'h0000_0300; cmd = 4'd3;
        for (int i = 0; i < 4; i++) begin
            irdy = i[0];
            @(negedge clk);
            chk("R11", outs(), 4'h0);
        end
        frame = 0; irdy = 0;
        @(negedge clk);
        txn(32'h0000_0301, 4'd3, 4'h0, 1'b1, 0, 4'b1001, "R11");

        // Reset in the middle of a decided transaction clears everything (R1).
        txn(32'h0000_0300, 4'd2, 4'hF, 1'b0, 0, 4'b1000, "R3");
        rst = 1;
        @(negedge clk);
        chk("R1", outs(), 4'h0);
        rst = 0;
        @(negedge clk);
        chk("R1", outs(), 4'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule